// File: doc/BRIEF.md
# Count-Committed Transmit Byte Buffer

This block is the transmit-side byte store of a serial port. The host stages outgoing bytes through a write window. Window offset zero always sits at the current write pointer. The staged bytes stay hidden from the transmitter until the host writes a byte count to the control register. That write adds the bytes to the fill count and moves the write pointer past them. Because window writes are byte-granular, the host can first stage one to three bytes to reach a 4-byte boundary and then continue with whole words.

A serialiser drains committed bytes in order through a fall-through pop port. A read of the control register returns the write pointer and the fill count. The block raises a space-available request whenever the free room reaches a level chosen by a 3-bit trigger code and the request is enabled. It also flags the transmitter as empty whenever nothing committed is left.

Top module: `txwin_fifo`

## Requirements
- R1: After reset, `ctl_rdata` reads 0, `tx_empty` is 1 and `pop_valid` is 0.
- R2: A window write with offset k stores its byte at buffer address (write pointer + k) mod 1024. Staged bytes leave the fill count, the write pointer and `tx_empty` unchanged.
- R3: A control write commits `ctl_wdata[9:0]` bytes, and bits [31:10] of the written value have no effect. `ctl_rdata` carries the write pointer in bits [9:0] and the fill count in bits [25:16], and all other bits read 0. With no commit and no pop, `ctl_rdata` holds its value.
- R4: The usable capacity is 1020 bytes. A commit larger than the free room (1020 − fill) is clamped to that room, and the fill count never exceeds 1020.
- R5: `pop_data` shows the oldest committed byte. Each accepted pop (`pop_req` while fill > 0) removes exactly one byte, in commit order. A pop request at fill 0 changes nothing.
- R6: When a commit and an accepted pop fall in the same cycle, the fill count changes by the clamped commit minus one. The clamp uses the free room from before that cycle's pop.
- R7: `space_req` is 1 exactly when `space_en` is 1 and the free room (1020 − fill) is at least 2^(`trig_code`+2) bytes. Code 5 therefore needs 128 bytes and code 0 needs 4.
- R8: `tx_empty` is 1 exactly when the fill count is 0. `pop_valid` is its inverse.
- R9: Window writes, commits and pops wrap from address 1023 to address 0 with no gap in the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_we | input | 1 | Window byte write strobe |
| win_off | input | 10 | Byte offset into the window, relative to the write pointer |
| win_data | input | 8 | Byte to stage |
| ctl_we | input | 1 | Control register write; commits a byte count |
| ctl_wdata | input | 32 | Control write value; bits [9:0] are the count |
| ctl_rdata | output | 32 | Write pointer in [9:0], fill count in [25:16] |
| trig_code | input | 3 | Space trigger code; the threshold is 2^(code+2) bytes |
| space_en | input | 1 | Enables the space-available request |
| pop_req | input | 1 | Serialiser takes the byte on `pop_data` |
| pop_data | output | 8 | Oldest committed byte |
| pop_valid | output | 1 | At least one committed byte is present |
| space_req | output | 1 | Space-available request |
| tx_empty | output | 1 | Fill count is zero |

## Verification
A host commit and a serialiser pop can land on the same clock edge, and both change the fill count. The bench drives `ctl_we` and `pop_req` together in a single cycle in three states: with bytes present, at fill 0 (where only the commit may count), and at full capacity (where the clamp must use the room that existed before the pop). In each case it reads the fill field back and compares it with the net change that R6 predicts.

// File: rtl/txwin_pkg.sv
package txwin_pkg;
    localparam int unsigned TXW_ADDR_W   = 10;
    localparam int unsigned TXW_DATA_W   = 8;
    localparam int unsigned TXW_RESERVE  = 4;
    localparam int unsigned TXW_CODE_W   = 3;
    localparam int unsigned TXW_REG_W    = 32;
    localparam int unsigned TXW_FILL_LSB = 16;
endpackage

// File: rtl/txwin_store.sv
module txwin_store #(
    parameter int unsigned ADDR_W = txwin_pkg::TXW_ADDR_W,
    parameter int unsigned DATA_W = txwin_pkg::TXW_DATA_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Byte array: one write port, asynchronous read for fall-through pop
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txwin_ctrl.sv
module txwin_ctrl #(
    parameter int unsigned ADDR_W  = txwin_pkg::TXW_ADDR_W,
    parameter int unsigned RESERVE = txwin_pkg::TXW_RESERVE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_we,
    input  logic [ADDR_W-1:0] commit_cnt,
    input  logic              pop_req,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [ADDR_W-1:0] fill,
    output logic [ADDR_W-1:0] free
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned CAP   = DEPTH - RESERVE;
    localparam logic [ADDR_W-1:0] CAP_V = ADDR_W'(CAP);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [ADDR_W-1:0] fill;
    } ctrl_st_t;

    ctrl_st_t          st_d, st_q;
    logic [ADDR_W-1:0] room;
    logic [ADDR_W-1:0] take;
    logic              pop_ok;

    always_comb begin
        // Room is judged before this cycle's pop (see R6)
        room   = CAP_V - st_q.fill;
        take   = '0;
        if (commit_we) begin
            take = (commit_cnt > room) ? room : commit_cnt;
        end
        pop_ok = pop_req && (st_q.fill != '0);

        st_d      = st_q;
        st_d.wptr = st_q.wptr + take;
        st_d.rptr = st_q.rptr + ADDR_W'(pop_ok);
        st_d.fill = st_q.fill + take - ADDR_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr = st_q.wptr;
    assign rptr = st_q.rptr;
    assign fill = st_q.fill;
    assign free = room;
endmodule

// File: rtl/txwin_space.sv
module txwin_space #(
    parameter int unsigned ADDR_W = txwin_pkg::TXW_ADDR_W,
    parameter int unsigned CODE_W = txwin_pkg::TXW_CODE_W
) (
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic [ADDR_W-1:0] free,
    output logic              req
);
    localparam int unsigned THR_W = ADDR_W + 1;

    logic [THR_W-1:0] thr;

    always_comb begin
        thr = THR_W'(1) << (int'(code) + 2);
        req = en && ({1'b0, free} >= thr);
    end
endmodule

// File: rtl/txwin_fifo.sv
module txwin_fifo #(
    parameter int unsigned ADDR_W   = txwin_pkg::TXW_ADDR_W,
    parameter int unsigned DATA_W   = txwin_pkg::TXW_DATA_W,
    parameter int unsigned RESERVE  = txwin_pkg::TXW_RESERVE,
    parameter int unsigned CODE_W   = txwin_pkg::TXW_CODE_W,
    parameter int unsigned REG_W    = txwin_pkg::TXW_REG_W,
    parameter int unsigned FILL_LSB = txwin_pkg::TXW_FILL_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [ADDR_W-1:0] win_off,
    input  logic [DATA_W-1:0] win_data,
    input  logic              ctl_we,
    input  logic [REG_W-1:0]  ctl_wdata,
    output logic [REG_W-1:0]  ctl_rdata,
    input  logic [CODE_W-1:0] trig_code,
    input  logic              space_en,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              space_req,
    output logic              tx_empty
);
    logic [ADDR_W-1:0] wptr, rptr, fill, free;
    logic [ADDR_W-1:0] stage_addr;
    logic              unused_ctl_hi;

    assign unused_ctl_hi = ^ctl_wdata[REG_W-1:ADDR_W];
    assign stage_addr    = wptr + win_off;

    txwin_ctrl #(.ADDR_W(ADDR_W), .RESERVE(RESERVE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_we  (ctl_we),
        .commit_cnt (ctl_wdata[ADDR_W-1:0]),
        .pop_req    (pop_req),
        .wptr       (wptr),
        .rptr       (rptr),
        .fill       (fill),
        .free       (free)
    );

    txwin_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (win_we),
        .waddr (stage_addr),
        .wdata (win_data),
        .raddr (rptr),
        .rdata (pop_data)
    );

    txwin_space #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_space (
        .en   (space_en),
        .code (trig_code),
        .free (free),
        .req  (space_req)
    );

    always_comb begin
        ctl_rdata                       = '0;
        ctl_rdata[ADDR_W-1:0]           = wptr;
        ctl_rdata[FILL_LSB +: ADDR_W]   = fill;
    end

    assign tx_empty  = (fill == '0);
    assign pop_valid = !tx_empty;
endmodule

// File: rtl/txwin_fifo_chk.sv
module txwin_fifo_chk #(
    parameter int unsigned ADDR_W   = txwin_pkg::TXW_ADDR_W,
    parameter int unsigned DATA_W   = txwin_pkg::TXW_DATA_W,
    parameter int unsigned RESERVE  = txwin_pkg::TXW_RESERVE,
    parameter int unsigned CODE_W   = txwin_pkg::TXW_CODE_W,
    parameter int unsigned REG_W    = txwin_pkg::TXW_REG_W,
    parameter int unsigned FILL_LSB = txwin_pkg::TXW_FILL_LSB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic [REG_W-1:0]  ctl_rdata,
    input logic              space_en,
    input logic              pop_req,
    input logic              space_req,
    input logic              tx_empty,
    input logic              win_we,
    input logic [DATA_W-1:0] pop_data
);
    localparam logic [ADDR_W-1:0] CAP_V = ADDR_W'((1 << ADDR_W) - RESERVE);

    logic [ADDR_W-1:0] fill_f, wptr_f;
    logic              unused_chk;

    assign fill_f     = ctl_rdata[FILL_LSB +: ADDR_W];
    assign wptr_f     = ctl_rdata[ADDR_W-1:0];
    assign unused_chk = win_we ^ (^pop_data);

    p_fill_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_f <= CAP_V);

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && !pop_req) |=> $stable(ctl_rdata));

    p_wptr_commit_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(wptr_f));

    p_pop_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && pop_req && !tx_empty) |=> (fill_f == $past(fill_f) - 1'b1));

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && pop_req && tx_empty) |=> tx_empty);

    p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !space_en |-> !space_req);

    p_full_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_f == CAP_V) |-> !space_req);
endmodule

bind txwin_fifo txwin_fifo_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESERVE(RESERVE),
    .CODE_W(CODE_W), .REG_W(REG_W), .FILL_LSB(FILL_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_rdata (ctl_rdata),
    .space_en  (space_en),
    .pop_req   (pop_req),
    .space_req (space_req),
    .tx_empty  (tx_empty),
    .win_we    (win_we),
    .pop_data  (pop_data)
);

// File: tb/txwin_fifo_test.sv
module txwin_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_we = 1'b0;
    logic [9:0]  win_off = '0;
    logic [7:0]  win_data = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [2:0]  trig_code = 3'd5;
    logic        space_en = 1'b1;
    logic        pop_req = 1'b0;
    logic [7:0]  pop_data;
    logic        pop_valid;
    logic        space_req;
    logic        tx_empty;

    int checks = 0;
    int errors = 0;
    int m_fill = 0;
    int m_wptr = 0;

    always #2 clk = ~clk;

    txwin_fifo uut (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_off(win_off),
        .win_data(win_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .trig_code(trig_code), .space_en(space_en),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .space_req(space_req), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(int'(ctl_rdata[9:0]) == m_wptr, {req, " wptr"}, int'(ctl_rdata[9:0]), m_wptr);
        chk(int'(ctl_rdata[25:16]) == m_fill, {req, " fill"}, int'(ctl_rdata[25:16]), m_fill);
        chk({ctl_rdata[31:26], ctl_rdata[15:10]} == '0, "R3 spare bits",
            int'({ctl_rdata[31:26], ctl_rdata[15:10]}), 0);
        chk(tx_empty == (m_fill == 0), "R8 empty", int'(tx_empty), int'(m_fill == 0));
        chk(pop_valid == (m_fill != 0), "R8 valid", int'(pop_valid), int'(m_fill != 0));
    endtask

    task automatic stage(input int off, input int data);
        win_we = 1'b1; win_off = 10'(off); win_data = 8'(data);
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic commit_pop(input int cnt, input bit pop, input logic [21:0] junk);
        int take;
        take = (cnt > 1020 - m_fill) ? 1020 - m_fill : cnt;
        ctl_we = 1'b1; ctl_wdata = {junk, 10'(cnt)}; pop_req = pop;
        @(negedge clk);
        ctl_we = 1'b0; pop_req = 1'b0;
        if (pop && m_fill != 0) m_fill--;
        m_fill += take;
        m_wptr = (m_wptr + take) % 1024;
    endtask

    task automatic pop_chk(input int exp, input string req);
        chk(int'(pop_data) == exp, {req, " pop data"}, int'(pop_data), exp);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        if (m_fill != 0) m_fill--;
    endtask

    task automatic drain();
        while (m_fill != 0) begin
            pop_req = 1'b1;
            @(negedge clk);
            pop_req = 1'b0;
            m_fill--;
        end
    endtask

    task automatic t_reset();
        chk(ctl_rdata == '0, "R1 rdata", int'(ctl_rdata), 0);
        chk(tx_empty == 1'b1, "R1 empty", int'(tx_empty), 1);
        chk(pop_valid == 1'b0, "R1 valid", int'(pop_valid), 0);
        chk(space_req == 1'b1, "R7 reset req", int'(space_req), 1);
    endtask

    task automatic t_stage_commit();
        stage(0, 8'h11); stage(1, 8'h22); stage(2, 8'h33);
        chk_state("R2 staged uncounted");
        commit_pop(3, 1'b0, 22'h3FFFFF);
        chk_state("R3 commit");
        pop_chk(8'h11, "R5"); pop_chk(8'h22, "R5"); pop_chk(8'h33, "R5");
        chk_state("R5 drained");
        pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;
        chk_state("R5 empty pop ignored");
    endtask

    task automatic t_offset_order();
        stage(3, 8'hA3); stage(0, 8'hA0); stage(2, 8'hA2); stage(1, 8'hA1);
        chk_state("R2 out of order staged");
        commit_pop(4, 1'b0, 22'h0);
        chk_state("R2 commit");
        for (int k = 0; k < 4; k++) pop_chk(8'hA0 + k, "R2");
        chk_state("R2 after pops");
    endtask

    task automatic t_clamp();
        commit_pop(1000, 1'b0, 22'h0);
        commit_pop(100, 1'b0, 22'h0);
        chk(m_fill == 1020, "R4 model", m_fill, 1020);
        chk_state("R4 clamp to room");
        commit_pop(5, 1'b0, 22'h155);
        chk_state("R4 full commit");
        chk(space_req == 1'b0, "R7 full", int'(space_req), 0);
        drain();
        chk_state("R4 drained");
    endtask

    task automatic t_trigger();
        trig_code = 3'd5; space_en = 1'b1;
        commit_pop(892, 1'b0, 22'h0);
        chk(space_req == 1'b1, "R7 code5 room128", int'(space_req), 1);
        commit_pop(1, 1'b0, 22'h0);
        chk(space_req == 1'b0, "R7 code5 room127", int'(space_req), 0);
        trig_code = 3'd4; #1;
        chk(space_req == 1'b1, "R7 code4 room127", int'(space_req), 1);
        space_en = 1'b0; #1;
        chk(space_req == 1'b0, "R7 disabled", int'(space_req), 0);
        space_en = 1'b1;
        @(negedge clk);
        drain();
        trig_code = 3'd0;
        commit_pop(1016, 1'b0, 22'h0);
        chk(space_req == 1'b1, "R7 code0 room4", int'(space_req), 1);
        commit_pop(1, 1'b0, 22'h0);
        chk(space_req == 1'b0, "R7 code0 room3", int'(space_req), 0);
        trig_code = 3'd7; #1;
        chk(space_req == 1'b0, "R7 code7 room3", int'(space_req), 0);
        @(negedge clk);
        drain();
        trig_code = 3'd7; #1;
        chk(space_req == 1'b1, "R7 code7 room1020", int'(space_req), 1);
        trig_code = 3'd5;
        @(negedge clk);
    endtask

    task automatic t_same_cycle();
        commit_pop(2, 1'b0, 22'h0);
        commit_pop(5, 1'b1, 22'h0);
        chk(m_fill == 6, "R6 model", m_fill, 6);
        chk_state("R6 commit and pop");
        drain();
        commit_pop(3, 1'b1, 22'h0);
        chk_state("R6 commit with empty pop");
        commit_pop(1017, 1'b0, 22'h0);
        commit_pop(10, 1'b1, 22'h0);
        chk(m_fill == 1019, "R6 model full", m_fill, 1019);
        chk_state("R6 full commit and pop");
        drain();
    endtask

    task automatic t_wrap();
        while (m_wptr != 1021) begin
            int c;
            c = (1021 - m_wptr + 1024) % 1024;
            if (c > 1020) c = 1020;
            commit_pop(c, 1'b0, 22'h0);
            drain();
        end
        for (int k = 0; k < 8; k++) stage(k, 8'hC0 + k);
        commit_pop(8, 1'b0, 22'h0);
        chk(m_wptr == 5, "R9 model", m_wptr, 5);
        chk_state("R9 wrapped commit");
        for (int k = 0; k < 8; k++) pop_chk(8'hC0 + k, "R9");
        chk_state("R9 drained");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_stage_commit();
        t_offset_order();
        t_clamp();
        t_trigger();
        t_same_cycle();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule